// File: doc/BRIEF.md
# NAND Asynchronous Read Strobe Sequencer

This block generates the active-low read-enable strobe for asynchronous NAND data-out cycles and latches the byte the memory presents. It can latch at the moment the strobe rises. It can also latch on a delayed copy of the strobe, so that data which only settles after the strobe has risen is still caught. This is the extended-data-out style used at pin rates above roughly 33 MHz. The whole block runs on one clock, `clk`, which is the eight-times oversampling clock. One controller clock period is eight `clk` cycles. The sample delay is a count of `clk` ticks, and each tick is one eighth of the reference period.

A client holds `rd_req` with a byte count on `rd_len`. The sequencer accepts the request with a one-cycle `rd_ack` and runs that many strobe cycles back to back. Each captured byte comes out on `rd_data` with a one-cycle `rd_valid`. Software-style settings arrive as plain inputs: low-phase and high-phase lengths in controller clocks, a 4-bit sample-delay code, a half-period flag and the delay-line enable. The delay code and the half-period flag are taken only while the delay line is off. After the delay line is switched on, no read may start until 64 controller clocks have passed.

The sequencer has three states: `ST_IDLE`, `ST_LOW` and `ST_HIGH`. The transitions are:
- `ST_IDLE`→`ST_LOW` on an accepted request.
- `ST_LOW`→`ST_HIGH` when the low-phase count expires. The strobe rises here.
- `ST_HIGH`→`ST_LOW` when the high-phase count expires and bytes remain.
- `ST_HIGH`→`ST_IDLE` when the high-phase count expires after the last byte.

Top module: `nand_rd_strobe`

## Requirements
- R1: While and after reset, `nand_re_n` is 1 and `rd_ack`, `rd_valid` and `rd_busy` are 0.
- R2: In `ST_IDLE`, if `rd_req` is high and the delay line is off or settled, the request is taken at the next edge. `rd_ack` is high for exactly that one cycle, `nand_re_n` falls on the same edge, and `rd_busy` stays 1 until the burst has finished.
- R3: Each low phase of `nand_re_n` lasts `cfg_setup`×8 `clk` cycles. A `cfg_setup` of 0 counts as 1.
- R4: Each high phase between bytes of a burst lasts `cfg_hold`×8 `clk` cycles, with no idle cycle between strobe cycles. A `cfg_hold` of 0 counts as 1. The final high phase ends in `ST_IDLE`.
- R5: With `dly_en` low, or with a tap count of 0, `rd_data` takes the value `nand_dq` had at the edge on which `nand_re_n` rises. `rd_valid` is high in the cycle after that edge.
- R6: With `dly_en` high, the tap count is `cfg_dly` when `cfg_half` is 0, and `cfg_dly`/2 rounded down when `cfg_half` is 1. `nand_dq` is sampled at the edge that many cycles after the edge on which `nand_re_n` rises, and `rd_valid` is high in the cycle after that sampling edge.
- R7: `cfg_dly` and `cfg_half` are taken only at edges where `dly_en` is low. Changes made while `dly_en` is high do not alter the sampling delay.
- R8: When `dly_en` rises, no request is accepted until 512 `clk` cycles (64 controller clocks) have passed. A request held from the rising edge is acknowledged at the 514th falling-edge sample after it.
- R9: A burst of `rd_len` bytes gives exactly `rd_len` `rd_valid` pulses. An `rd_len` of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, eight ticks per controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_setup | input | CYC_W | Strobe low time in controller clocks |
| cfg_hold | input | CYC_W | Strobe high time in controller clocks |
| cfg_dly | input | DLY_W | Sample-delay code |
| cfg_half | input | 1 | Reference period is half the controller period |
| dly_en | input | 1 | Delay-line enable |
| rd_req | input | 1 | Read request, held until acknowledged |
| rd_len | input | LEN_W | Bytes in the burst |
| rd_ack | output | 1 | One-cycle request acceptance |
| rd_busy | output | 1 | Burst in progress |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq | input | DQ_W | Data from the memory |
| rd_data | output | DQ_W | Captured byte |
| rd_valid | output | 1 | One-cycle pulse per captured byte |

## Verification
The bench drives `nand_dq` with the running edge count. A captured byte therefore shows exactly which edge sampled it. For a strobe rise at edge E with a tap count d, the bench expects `rd_valid` at the falling-edge sample after edge E+d, with data E+d−1. The strobe widths are counted in falling-edge samples and must equal 8×setup and 8×hold. The acknowledge is due one sample after the request when the delay line is off or already settled, and 514 samples after it when the delay line is switched on together with the request. All sampling is done on the falling clock edge, so each expectation refers to a single, named cycle.

// File: rtl/nrs_pkg.sv
`timescale 1ns/1ps
package nrs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } rd_state_t;
endpackage

// File: rtl/nrs_settle.sv
`timescale 1ns/1ps
// Holds off new reads until the delay line has settled after being enabled.
module nrs_settle #(
    parameter int SETTLE_OS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dly_en,
    output logic ready
);
    localparam int CW = $clog2(SETTLE_OS + 1);

    logic          en_q;
    logic [CW-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            wait_cnt <= '0;
        end else begin
            en_q <= dly_en;
            if (!dly_en)
                wait_cnt <= '0;
            else if (!en_q)
                wait_cnt <= CW'(SETTLE_OS);
            else if (wait_cnt != '0)
                wait_cnt <= wait_cnt - 1'b1;
        end
    end

    assign ready = (wait_cnt == '0) && !(dly_en && !en_q);
endmodule

// File: rtl/nrs_tap_cfg.sv
`timescale 1ns/1ps
// Freezes the delay code and half-period flag while the delay line runs,
// and converts them to oversampled ticks.
module nrs_tap_cfg #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dly_en,
    input  logic [DLY_W-1:0] cfg_dly,
    input  logic             cfg_half,
    output logic [DLY_W-1:0] taps
);
    logic [DLY_W-1:0] dly_q;
    logic             half_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q  <= '0;
            half_q <= 1'b0;
        end else if (!dly_en) begin
            dly_q  <= cfg_dly;
            half_q <= cfg_half;
        end
    end

    always_comb begin
        if (!dly_en)
            taps = '0;
        else if (half_q)
            taps = dly_q >> 1;
        else
            taps = dly_q;
    end

    // R7: with the delay line held on, the tap count must not move
    a_r7_taps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_en && $past(dly_en)) |-> $stable(taps));
endmodule

// File: rtl/nrs_capture.sv
`timescale 1ns/1ps
// Samples the data bus on a tick-delayed copy of the strobe rising edge.
module nrs_capture #(
    parameter int DQ_W  = 8,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [DLY_W-1:0] taps,
    input  logic [DQ_W-1:0]  dq,
    output logic [DQ_W-1:0]  rd_data,
    output logic             rd_valid
);
    logic             pend;
    logic [DLY_W-1:0] tick_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            tick_cnt <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (rise) begin
                if (taps == '0) begin
                    rd_data  <= dq;
                    rd_valid <= 1'b1;
                end else begin
                    pend     <= 1'b1;
                    tick_cnt <= taps;
                end
            end else if (pend) begin
                if (tick_cnt == DLY_W'(1)) begin
                    rd_data  <= dq;
                    rd_valid <= 1'b1;
                    pend     <= 1'b0;
                end else begin
                    tick_cnt <= tick_cnt - 1'b1;
                end
            end
        end
    end

    // R6: a delayed sample never overlaps the next strobe rise
    a_r6_single_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> !pend);
    // R9: one captured byte gives a single-cycle pulse
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/nand_rd_strobe.sv
`timescale 1ns/1ps
module nand_rd_strobe
    import nrs_pkg::*;
#(
    parameter int CYC_W       = 6,
    parameter int LEN_W       = 8,
    parameter int DQ_W        = 8,
    parameter int DLY_W       = 4,
    parameter int OS_LOG      = 3,
    parameter int SETTLE_CTRL = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] cfg_setup,
    input  logic [CYC_W-1:0] cfg_hold,
    input  logic [DLY_W-1:0] cfg_dly,
    input  logic             cfg_half,
    input  logic             dly_en,
    input  logic             rd_req,
    input  logic [LEN_W-1:0] rd_len,
    output logic             rd_ack,
    output logic             rd_busy,
    output logic             nand_re_n,
    input  logic [DQ_W-1:0]  nand_dq,
    output logic [DQ_W-1:0]  rd_data,
    output logic             rd_valid
);
    localparam int PH_W      = CYC_W + OS_LOG;
    localparam int SETTLE_OS = SETTLE_CTRL << OS_LOG;

    rd_state_t        state, state_nx;
    logic [PH_W-1:0]  ph_cnt;
    logic [LEN_W-1:0] left;
    logic [CYC_W-1:0] su_q, hd_q;
    logic             dll_ready, accept, ph_done, rise;
    logic [DLY_W-1:0] taps;

    function automatic logic [PH_W-1:0] phase_len(input logic [CYC_W-1:0] n);
        logic [CYC_W-1:0] nz;
        nz = (n == '0) ? CYC_W'(1) : n;
        return {nz, {OS_LOG{1'b0}}} - PH_W'(1);
    endfunction

    nrs_settle #(.SETTLE_OS(SETTLE_OS)) i_settle (
        .clk(clk), .rst_n(rst_n), .dly_en(dly_en), .ready(dll_ready)
    );

    nrs_tap_cfg #(.DLY_W(DLY_W)) i_tap_cfg (
        .clk(clk), .rst_n(rst_n), .dly_en(dly_en),
        .cfg_dly(cfg_dly), .cfg_half(cfg_half), .taps(taps)
    );

    nrs_capture #(.DQ_W(DQ_W), .DLY_W(DLY_W)) i_capture (
        .clk(clk), .rst_n(rst_n), .rise(rise), .taps(taps),
        .dq(nand_dq), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assign accept  = (state == ST_IDLE) && rd_req && dll_ready;
    assign ph_done = (ph_cnt == '0);
    assign rise    = (state == ST_LOW) && ph_done;
    assign rd_busy = (state != ST_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)  state_nx = ST_LOW;
            ST_LOW:  if (ph_done) state_nx = ST_HIGH;
            ST_HIGH: if (ph_done) state_nx = (left == '0) ? ST_IDLE : ST_LOW;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nand_re_n <= 1'b1;
            rd_ack    <= 1'b0;
            ph_cnt    <= '0;
            left      <= '0;
            su_q      <= CYC_W'(1);
            hd_q      <= CYC_W'(1);
        end else begin
            rd_ack <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        rd_ack    <= 1'b1;
                        nand_re_n <= 1'b0;
                        su_q      <= cfg_setup;
                        hd_q      <= cfg_hold;
                        ph_cnt    <= phase_len(cfg_setup);
                        left      <= (rd_len == '0) ? '0 : rd_len - 1'b1;
                    end
                end
                ST_LOW: begin
                    if (ph_done) begin
                        nand_re_n <= 1'b1;
                        ph_cnt    <= phase_len(hd_q);
                    end else begin
                        ph_cnt <= ph_cnt - 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (ph_done) begin
                        if (left != '0) begin
                            nand_re_n <= 1'b0;
                            left      <= left - 1'b1;
                            ph_cnt    <= phase_len(su_q);
                        end
                    end else begin
                        ph_cnt <= ph_cnt - 1'b1;
                    end
                end
                default: nand_re_n <= 1'b1;
            endcase
        end
    end

    // R2: acceptance coincides with the strobe falling and the burst starting
    a_r2_ack_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> (!nand_re_n && rd_busy));
    // R8: nothing is accepted while the delay line settles
    a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        !dll_ready |=> !rd_ack);
    // R3: the strobe is low throughout the low phase
    a_r3_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW) |-> !nand_re_n);
    // R1: idle means the strobe is released
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> nand_re_n);
endmodule

// File: tb/test_nand_rd_strobe.sv
`timescale 1ns/1ps
module test_nand_rd_strobe;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_setup = '0, cfg_hold = '0;
    logic [3:0] cfg_dly = '0;
    logic       cfg_half = 1'b0, dly_en = 1'b0, rd_req = 1'b0;
    logic [7:0] rd_len = '0, nand_dq = '0;
    logic       rd_ack, rd_busy, nand_re_n, rd_valid;
    logic [7:0] rd_data;

    int n_chk = 0, n_err = 0;
    int cyc = 0;
    int exp_su = 1, exp_hd = 1, exp_taps = 0;
    int low_len = 0, high_len = 0, exp_cyc = 0, exp_val = 0, nvalid = 0;
    bit armed = 0, mon_pend = 0, prev_re = 1;
    string cap_tag = "R5";

    always #5 clk = ~clk;

    nand_rd_strobe i_nand_rd_strobe (
        .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
        .cfg_dly(cfg_dly), .cfg_half(cfg_half), .dly_en(dly_en),
        .rd_req(rd_req), .rd_len(rd_len), .rd_ack(rd_ack), .rd_busy(rd_busy),
        .nand_re_n(nand_re_n), .nand_dq(nand_dq), .rd_data(rd_data),
        .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Strobe-width and capture monitor; drives nand_dq with the edge count
    always @(negedge clk) begin
        if (rst_n) begin
            if (nand_re_n && !prev_re) begin
                chk(low_len == exp_su * 8, "R3 low width", low_len, exp_su * 8);
                low_len  = 0;
                high_len = 1;
                armed    = 1;
                mon_pend = 1;
                exp_cyc  = cyc + exp_taps;
                exp_val  = (cyc + exp_taps - 1) & 255;
            end else if (!nand_re_n && prev_re) begin
                if (armed)
                    chk(high_len == exp_hd * 8, "R4 high width", high_len, exp_hd * 8);
                low_len = 1;
            end else if (nand_re_n) begin
                high_len++;
            end else begin
                low_len++;
            end
            if (!rd_busy) armed = 0;
            if (rd_valid) begin
                nvalid++;
                chk(mon_pend && cyc == exp_cyc, {cap_tag, " sample time"}, cyc, exp_cyc);
                chk(int'(rd_data) == exp_val, {cap_tag, " sample data"}, int'(rd_data), exp_val);
                mon_pend = 0;
            end else if (mon_pend && cyc > exp_cyc) begin
                chk(0, {cap_tag, " missing valid"}, cyc, exp_cyc);
                mon_pend = 0;
            end
            prev_re = nand_re_n;
        end
        nand_dq = cyc[7:0];
    end

    task automatic set_cfg(input int su, input int hd, input int dly, input bit half);
        @(negedge clk);
        dly_en = 1'b0;
        repeat (2) @(negedge clk);
        cfg_setup = 6'(su); cfg_hold = 6'(hd);
        cfg_dly = 4'(dly); cfg_half = half;
        exp_su = (su == 0) ? 1 : su;
        exp_hd = (hd == 0) ? 1 : hd;
        @(negedge clk);
    endtask

    task automatic do_read(input int len, input int exp_lat, input int exp_n, input string tag);
        int lat = 0;
        int start_n = nvalid;
        rd_len = 8'(len);
        rd_req = 1'b1;
        do begin
            @(negedge clk);
            lat++;
        end while (!rd_ack && lat < 2000);
        rd_req = 1'b0;
        chk(lat == exp_lat, {tag, " ack latency"}, lat, exp_lat);
        while (rd_busy || mon_pend) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(nvalid - start_n == exp_n, "R9 byte count", nvalid - start_n, exp_n);
    endtask

    task automatic t_reset();
        chk(nand_re_n == 1'b1, "R1 strobe", int'(nand_re_n), 1);
        chk(rd_ack == 1'b0, "R1 ack", int'(rd_ack), 0);
        chk(rd_valid == 1'b0, "R1 valid", int'(rd_valid), 0);
        chk(rd_busy == 1'b0, "R1 busy", int'(rd_busy), 0);
    endtask

    task automatic t_edge_sample();
        set_cfg(2, 1, 9, 0);
        exp_taps = 0; cap_tag = "R5";
        do_read(1, 1, 1, "R2");
    endtask

    task automatic t_zero_counts();
        set_cfg(0, 0, 0, 0);
        exp_taps = 0; cap_tag = "R5";
        do_read(3, 1, 3, "R2");
    endtask

    task automatic t_len_zero();
        set_cfg(1, 2, 0, 0);
        exp_taps = 0; cap_tag = "R5";
        do_read(0, 1, 1, "R9");
    endtask

    task automatic t_delay_full();
        set_cfg(1, 1, 5, 0);
        exp_taps = 5; cap_tag = "R6";
        dly_en = 1'b1;
        do_read(2, 514, 2, "R8");
    endtask

    task automatic t_delay_half();
        set_cfg(2, 1, 7, 1);
        exp_taps = 3; cap_tag = "R6";
        dly_en = 1'b1;
        do_read(2, 514, 2, "R8");
    endtask

    task automatic t_locked();
        // delay line still on from t_delay_half: new code must be ignored (R7)
        @(negedge clk);
        cfg_dly = 4'd12; cfg_half = 1'b0;
        exp_taps = 3; cap_tag = "R7";
        do_read(1, 1, 1, "R7");
    endtask

    task automatic t_edo_trail();
        set_cfg(1, 1, 15, 0);
        exp_taps = 15; cap_tag = "R6";
        dly_en = 1'b1;
        do_read(4, 514, 4, "R8");
    endtask

    task automatic t_tap_zero();
        set_cfg(1, 1, 1, 1);
        exp_taps = 0; cap_tag = "R5";
        dly_en = 1'b1;
        do_read(2, 514, 2, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge_sample();
        t_zero_counts();
        t_len_zero();
        t_delay_full();
        t_delay_half();
        t_locked();
        t_edo_trail();
        t_tap_zero();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule